// File: doc/BRIEF.md
# Interrupt Status And Signaling Unit

This block keeps the interrupt state of a storage host adapter. It holds a status register, where completion and message events set their own bits, and a mask register that software loads to select which of those bits may interrupt. It also holds the adapter's command status word, which the command engine loads and software reads back. Software reaches all three through 32-bit register reads and writes. Only 4-byte accesses are accepted. Status bits are cleared by writing ones to them.

The pending-and-enabled condition is the bitwise AND of mask and status, tested for any set bit. The block signals this condition in one of two ways. With message-signaled interrupts not active, the condition drives a level-sensitive legacy interrupt line. With message-signaled interrupts set up and enabled, every update of status or mask that leaves the condition true produces a single-clock request pulse. A condition that is false at an update deasserts nothing in that mode. Each accepted status write also asks the completion path to deliver again if completions are still queued. The bus write that carries the interrupt message is built outside this block.

Top module: `isu_top`

## Requirements
- R1: After synchronous reset, status, mask and command status read as 0, and intx_level, msi_pulse and resched_req are low.
- R2: A read with rd_en high and acc_size equal to 4 returns status at offset 0x00, mask at offset 0x04 and command status at offset 0x08 in the same cycle. Any other offset, or any other access size, reads as 0.
- R3: An accepted write to offset 0x04 replaces the whole mask. The new mask reads back after the write edge.
- R4: An accepted write to offset 0x00 clears exactly the status bits written as 1 and leaves all other bits unchanged.
- R5: A pulse on cmpl_evt sets status bit 0 and a pulse on msg_evt sets status bit 12. An event wins over a clear of the same bit written in the same cycle.
- R6: While msi_ok and msi_en are not both high, intx_level equals (mask AND status) != 0 as registered at the last edge. While both are high, intx_level is low.
- R7: While msi_ok and msi_en are both high, msi_pulse is high for exactly the one cycle after each update edge at which (mask AND status) != 0 after the update. An update is an accepted status or mask write, cmpl_evt or msg_evt. No pulse follows an update that leaves the condition false, and no pulse follows a cycle without an update.
- R8: An accepted status write made while cmpl_queued is high raises resched_req for the one following cycle. Without cmpl_queued, no request is raised.
- R9: adapter_reset clears status at the next edge and takes priority over events in the same cycle. The mask is kept.
- R10: Writes with acc_size other than 4, and writes to offsets other than 0x00 and 0x04, change no register.
- R11: cmd_status_we loads cmd_status_val into the command status register, which reads back at offset 0x08 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read enable |
| addr | input | 8 | Register byte offset |
| acc_size | input | 3 | Access size in bytes |
| wdata | input | 32 | Write data, little-endian word |
| rdata | output | 32 | Read data, combinational |
| cmpl_evt | input | 1 | Completion event pulse |
| msg_evt | input | 1 | Message event pulse |
| adapter_reset | input | 1 | Adapter reset pulse, clears status |
| cmpl_queued | input | 1 | Completions are waiting for delivery |
| msi_ok | input | 1 | Message interrupt setup succeeded |
| msi_en | input | 1 | Message interrupt enabled |
| cmd_status_we | input | 1 | Command status load strobe |
| cmd_status_val | input | 32 | Command status value |
| intx_level | output | 1 | Legacy level interrupt |
| msi_pulse | output | 1 | One-cycle message interrupt request |
| resched_req | output | 1 | One-cycle completion redelivery request |

## Verification
Register state, intx_level, msi_pulse and resched_req all change at the first clock edge after a stimulus is presented, so each of these results is due one cycle after the stimulus. rdata is combinational and is due in the same cycle as the read. The bench drives every stimulus on a falling edge and releases it 1 ns after the next rising edge. It samples the pulse outputs and the level at that point, inside the single cycle in which a pulse may be high. It then reads the registers back with the strobes idle. The no-pulse and ignored-write cases are checked at the same point and by read-back, so a late or missing update shows up as a mismatch.

// File: rtl/isu_pkg.sv
package isu_pkg;
    // Register byte offsets
    localparam logic [7:0] OFF_STATUS = 8'h00;
    localparam logic [7:0] OFF_MASK   = 8'h04;
    localparam logic [7:0] OFF_CMDST  = 8'h08;
    localparam int unsigned ACC_BYTES = 4;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_MASK,
        SEL_CMDST
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [7:0] a, input logic [2:0] sz);
        reg_sel_e s;
        s = SEL_NONE;
        if (sz == 3'(ACC_BYTES)) begin
            case (a)
                OFF_STATUS: s = SEL_STATUS;
                OFF_MASK:   s = SEL_MASK;
                OFF_CMDST:  s = SEL_CMDST;
                default:    s = SEL_NONE;
            endcase
        end
        return s;
    endfunction
endpackage

// File: rtl/isu_regs.sv
module isu_regs
    import isu_pkg::*;
#(
    parameter int DW       = 32,
    parameter int AW       = 8,
    parameter int CMPL_BIT = 0,
    parameter int MSG_BIT  = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [2:0]    acc_size,
    input  logic [DW-1:0] wdata,
    input  logic          cmpl_evt,
    input  logic          msg_evt,
    input  logic          adapter_reset,
    input  logic          cmd_status_we,
    input  logic [DW-1:0] cmd_status_val,
    output logic [DW-1:0] status_q,
    output logic [DW-1:0] mask_q,
    output logic [DW-1:0] rdata,
    output logic          upd,
    output logic          cond_nxt,
    output logic          st_wr
);
    reg_sel_e      sel;
    logic [DW-1:0] cmdst_q;
    logic [DW-1:0] status_d;
    logic [DW-1:0] mask_d;
    logic [DW-1:0] evt_set;
    logic          mk_wr;

    assign sel   = decode_sel(8'(addr), acc_size);
    assign st_wr = wr_en && (sel == SEL_STATUS);
    assign mk_wr = wr_en && (sel == SEL_MASK);

    always_comb begin
        evt_set = '0;
        evt_set[CMPL_BIT] = cmpl_evt;
        evt_set[MSG_BIT]  = msg_evt;
    end

    always_comb begin
        status_d = status_q;
        if (st_wr)
            status_d = status_d & ~wdata;
        status_d = status_d | evt_set;
        if (adapter_reset)
            status_d = '0;
        mask_d = mk_wr ? wdata : mask_q;
    end

    assign upd      = st_wr || mk_wr || cmpl_evt || msg_evt;
    assign cond_nxt = |(status_d & mask_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            mask_q   <= '0;
            cmdst_q  <= '0;
        end else begin
            status_q <= status_d;
            mask_q   <= mask_d;
            if (cmd_status_we)
                cmdst_q <= cmd_status_val;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (sel)
                SEL_STATUS: rdata = status_q;
                SEL_MASK:   rdata = mask_q;
                SEL_CMDST:  rdata = cmdst_q;
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/isu_sig.sv
module isu_sig #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          msi_active,
    input  logic          upd,
    input  logic          cond_nxt,
    input  logic          st_wr,
    input  logic          cmpl_queued,
    input  logic [DW-1:0] status_q,
    input  logic [DW-1:0] mask_q,
    output logic          intx_level,
    output logic          msi_pulse,
    output logic          resched_req
);
    assign intx_level = !msi_active && (|(status_q & mask_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            msi_pulse   <= 1'b0;
            resched_req <= 1'b0;
        end else begin
            msi_pulse   <= msi_active && upd && cond_nxt;
            resched_req <= st_wr && cmpl_queued;
        end
    end
endmodule

// File: rtl/isu_top.sv
module isu_top #(
    parameter int DW       = 32,
    parameter int AW       = 8,
    parameter int CMPL_BIT = 0,
    parameter int MSG_BIT  = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [2:0]    acc_size,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          cmpl_evt,
    input  logic          msg_evt,
    input  logic          adapter_reset,
    input  logic          cmpl_queued,
    input  logic          msi_ok,
    input  logic          msi_en,
    input  logic          cmd_status_we,
    input  logic [DW-1:0] cmd_status_val,
    output logic          intx_level,
    output logic          msi_pulse,
    output logic          resched_req
);
    logic [DW-1:0] status_q;
    logic [DW-1:0] mask_q;
    logic          upd;
    logic          cond_nxt;
    logic          st_wr;
    logic          msi_active;

    assign msi_active = msi_ok && msi_en;

    isu_regs #(.DW(DW), .AW(AW), .CMPL_BIT(CMPL_BIT), .MSG_BIT(MSG_BIT)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .acc_size(acc_size), .wdata(wdata), .cmpl_evt(cmpl_evt), .msg_evt(msg_evt),
        .adapter_reset(adapter_reset), .cmd_status_we(cmd_status_we),
        .cmd_status_val(cmd_status_val), .status_q(status_q), .mask_q(mask_q),
        .rdata(rdata), .upd(upd), .cond_nxt(cond_nxt), .st_wr(st_wr)
    );

    isu_sig #(.DW(DW)) u_sig (
        .clk(clk), .rst(rst), .msi_active(msi_active), .upd(upd),
        .cond_nxt(cond_nxt), .st_wr(st_wr), .cmpl_queued(cmpl_queued),
        .status_q(status_q), .mask_q(mask_q), .intx_level(intx_level),
        .msi_pulse(msi_pulse), .resched_req(resched_req)
    );
endmodule

// File: rtl/isu_checker.sv
module isu_checker #(
    parameter int DW       = 32,
    parameter int CMPL_BIT = 0,
    parameter int MSG_BIT  = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [7:0]    addr,
    input logic [2:0]    acc_size,
    input logic [DW-1:0] wdata,
    input logic          cmpl_evt,
    input logic          msg_evt,
    input logic          adapter_reset,
    input logic          cmpl_queued,
    input logic          msi_ok,
    input logic          msi_en,
    input logic [DW-1:0] status_q,
    input logic [DW-1:0] mask_q,
    input logic          intx_level,
    input logic          msi_pulse,
    input logic          resched_req
);
    p_cmpl_set_r5: assert property (@(posedge clk) disable iff (rst)
        (cmpl_evt && !adapter_reset) |=> status_q[CMPL_BIT]);

    p_msg_set_r5: assert property (@(posedge clk) disable iff (rst)
        (msg_evt && !adapter_reset) |=> status_q[MSG_BIT]);

    p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 8'h00 && acc_size == 3'd4 && !cmpl_evt && !msg_evt)
        |=> ((status_q & $past(wdata)) == '0));

    p_msi_no_level_r6: assert property (@(posedge clk) disable iff (rst)
        (msi_ok && msi_en) |-> !intx_level);

    p_pulse_mode_r7: assert property (@(posedge clk) disable iff (rst)
        msi_pulse |-> ($past(msi_ok) && $past(msi_en)));

    p_resched_src_r8: assert property (@(posedge clk) disable iff (rst)
        resched_req |-> $past(cmpl_queued));

    p_areset_r9: assert property (@(posedge clk) disable iff (rst)
        adapter_reset |=> (status_q == '0));

    p_bad_size_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && acc_size != 3'd4) |=> $stable(mask_q));
endmodule

bind isu_top isu_checker #(.DW(DW), .CMPL_BIT(CMPL_BIT), .MSG_BIT(MSG_BIT)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(8'(addr)), .acc_size(acc_size),
    .wdata(wdata), .cmpl_evt(cmpl_evt), .msg_evt(msg_evt),
    .adapter_reset(adapter_reset), .cmpl_queued(cmpl_queued), .msi_ok(msi_ok),
    .msi_en(msi_en), .status_q(status_q), .mask_q(mask_q),
    .intx_level(intx_level), .msi_pulse(msi_pulse), .resched_req(resched_req)
);

// File: tb/tb_isu_top.sv
module tb_isu_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en;
    logic [7:0]  addr;
    logic [2:0]  acc_size;
    logic [31:0] wdata, rdata;
    logic        cmpl_evt, msg_evt, adapter_reset, cmpl_queued;
    logic        msi_ok, msi_en, cmd_status_we;
    logic [31:0] cmd_status_val;
    logic        intx_level, msi_pulse, resched_req;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    isu_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .acc_size(acc_size), .wdata(wdata), .rdata(rdata), .cmpl_evt(cmpl_evt),
        .msg_evt(msg_evt), .adapter_reset(adapter_reset), .cmpl_queued(cmpl_queued),
        .msi_ok(msi_ok), .msi_en(msi_en), .cmd_status_we(cmd_status_we),
        .cmd_status_val(cmd_status_val), .intx_level(intx_level),
        .msi_pulse(msi_pulse), .resched_req(resched_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; rd_en = 0; addr = 0; acc_size = 3'd4; wdata = 0;
        cmpl_evt = 0; msg_evt = 0; adapter_reset = 0; cmd_status_we = 0;
    endtask

    // hold the driven inputs over one rising edge, release after it
    task automatic step();
        @(posedge clk); #1;
        idle();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [2:0] sz);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d; acc_size = sz;
        step();
    endtask

    task automatic rd(input logic [7:0] a, input logic [2:0] sz, output logic [31:0] d);
        rd_en = 1; addr = a; acc_size = sz;
        #1 d = rdata;
        rd_en = 0; addr = 0; acc_size = 3'd4;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h00, 3'd4, d); check("R1 status", d, 0);
        rd(8'h04, 3'd4, d); check("R1 mask", d, 0);
        rd(8'h08, 3'd4, d); check("R1 cmdst", d, 0);
        check("R1 outputs", {intx_level, msi_pulse, resched_req}, 0);
    endtask

    task automatic t_mask_and_map();
        logic [31:0] d;
        wr(8'h04, 32'h0000_1001, 3'd4);
        rd(8'h04, 3'd4, d); check("R3 mask", d, 32'h0000_1001);
        wr(8'h04, 32'hA5A5_0000, 3'd4);
        rd(8'h04, 3'd4, d); check("R3 mask replace", d, 32'hA5A5_0000);
        rd(8'h10, 3'd4, d); check("R2 unknown offset", d, 0);
        rd(8'h04, 3'd2, d); check("R2 bad size read", d, 0);
        wr(8'h04, 32'h0000_1001, 3'd4);
    endtask

    task automatic t_cmdst();
        logic [31:0] d;
        @(negedge clk);
        cmd_status_we = 1; cmd_status_val = 32'hDEAD_0007;
        step();
        rd(8'h08, 3'd4, d); check("R11 cmdst", d, 32'hDEAD_0007);
        rd(8'h08, 3'd4, d); check("R2 cmdst offset", d, 32'hDEAD_0007);
    endtask

    task automatic t_events_intx();
        logic [31:0] d;
        @(negedge clk); cmpl_evt = 1; step();
        rd(8'h00, 3'd4, d); check("R5 cmpl bit0", d, 32'h0000_0001);
        check("R6 intx high", intx_level, 1);
        check("R7 no pulse in level mode", msi_pulse, 0);
        @(negedge clk); msg_evt = 1; step();
        rd(8'h00, 3'd4, d); check("R5 msg bit12", d, 32'h0000_1001);
        wr(8'h04, 32'h0000_1000, 3'd4);
        check("R6 intx masked still pending", intx_level, 1);
        wr(8'h04, 32'h0000_0000, 3'd4);
        check("R6 intx masked off", intx_level, 0);
        wr(8'h04, 32'h0000_1001, 3'd4);
        check("R6 intx back", intx_level, 1);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(8'h00, 32'h0000_0001, 3'd4);
        rd(8'h00, 3'd4, d); check("R4 clear bit0 only", d, 32'h0000_1000);
        check("R8 no resched without queue", resched_req, 0);
        // clear and set same bit in one cycle: set wins
        @(negedge clk);
        wr_en = 1; addr = 8'h00; wdata = 32'h0000_1001; cmpl_evt = 1;
        step();
        rd(8'h00, 3'd4, d); check("R5 event beats clear", d, 32'h0000_0001);
        wr(8'h00, 32'hFFFF_FFFF, 3'd4);
        rd(8'h00, 3'd4, d); check("R4 clear all", d, 0);
        check("R6 intx low after clear", intx_level, 0);
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        @(negedge clk); cmpl_evt = 1; msg_evt = 1; step();
        wr(8'h00, 32'hFFFF_FFFF, 3'd2);
        rd(8'h00, 3'd4, d); check("R10 bad size status write", d, 32'h0000_1001);
        wr(8'h04, 32'h0, 3'd1);
        rd(8'h04, 3'd4, d); check("R10 bad size mask write", d, 32'h0000_1001);
        wr(8'h0C, 32'hFFFF_FFFF, 3'd4);
        rd(8'h00, 3'd4, d); check("R10 unknown offset status", d, 32'h0000_1001);
        rd(8'h04, 3'd4, d); check("R10 unknown offset mask", d, 32'h0000_1001);
        wr(8'h08, 32'h1234_5678, 3'd4);
        rd(8'h08, 3'd4, d); check("R10 cmdst not writable", d, 32'hDEAD_0007);
    endtask

    task automatic t_resched();
        cmpl_queued = 1;
        wr(8'h00, 32'h0, 3'd4);
        check("R8 resched pulse", resched_req, 1);
        @(posedge clk); #1;
        check("R8 resched one cycle", resched_req, 0);
        cmpl_queued = 0;
    endtask

    task automatic t_areset();
        logic [31:0] d;
        @(negedge clk); adapter_reset = 1; msg_evt = 1; step();
        rd(8'h00, 3'd4, d); check("R9 status cleared", d, 0);
        rd(8'h04, 3'd4, d); check("R9 mask kept", d, 32'h0000_1001);
    endtask

    task automatic t_msi();
        logic [31:0] d;
        msi_ok = 1; msi_en = 1;
        @(negedge clk); cmpl_evt = 1; step();
        check("R7 pulse on raise", msi_pulse, 1);
        check("R6 no level in msi", intx_level, 0);
        @(posedge clk); #1;
        check("R7 pulse one cycle", msi_pulse, 0);
        wr(8'h04, 32'h0000_1001, 3'd4);
        check("R7 pulse on mask update still true", msi_pulse, 1);
        wr(8'h00, 32'h0000_0001, 3'd4);
        check("R7 no pulse when false", msi_pulse, 0);
        @(negedge clk); msg_evt = 1; step();
        check("R7 pulse msg event", msi_pulse, 1);
        wr(8'h04, 32'h0, 3'd4);
        check("R7 no pulse masked", msi_pulse, 0);
        rd(8'h00, 3'd4, d); check("R7 status kept", d, 32'h0000_1000);
        msi_en = 0;
        #1 check("R6 level when msi disabled (masked)", intx_level, 0);
        wr(8'h04, 32'h0000_1000, 3'd4);
        check("R6 level resumes", intx_level, 1);
        check("R7 no pulse msi off", msi_pulse, 0);
    endtask

    initial begin
        idle();
        cmpl_queued = 0; msi_ok = 0; msi_en = 0; cmd_status_val = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_mask_and_map();
        t_cmdst();
        t_events_intx();
        t_w1c();
        t_ignored();
        t_resched();
        t_areset();
        t_msi();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule